// File: doc/BRIEF.md
# Subset Instruction Execute Unit

This block executes one 32-bit instruction word per clock from a small arithmetic subset that has no memory access. Each cycle it splits the word into its fields and reads two source values from a 32-entry, 32-bit register file. It builds the immediate operand, computes a result and writes that result back to the destination register on the next rising clock edge.

Four operations are supported: register-register add, add-immediate, load-upper-immediate and or-immediate. Load-upper-immediate followed by or-immediate on the same register builds any 32-bit constant in two instructions. Each immediate operation extends its 16-bit field in its own way: sign extension, placement in the upper half, or zero extension. Any other encoding raises an illegal flag for that cycle and writes nothing.

The computed result, the write strobe and the write address are driven on outputs in the same cycle. To observe the register state, issue an add whose destination is register 0. It shows a register value on the result output and changes nothing.

Top module: `subset_exec_unit`

## Requirements
- R1: An instruction with opcode field [31:26] = 0 and function field [5:0] = 32 writes rs[25:21] + rt[20:16] into rd[15:11]. The sum wraps modulo 2^32 and raises no trap.
- R2: Opcode 8 writes rs plus the sign-extended imm[15:0] into rt[20:16], wrapping modulo 2^32.
- R3: Opcode 15 writes {imm[15:0], 16'h0000} into rt. Bits 15:0 of the result are always zero.
- R4: Opcode 13 writes rs OR the zero-extended imm[15:0] into rt.
- R5: Register 0 always reads as zero. A write addressed to it is discarded, although the strobe and result still appear on the outputs.
- R6: When valid_i is high and the opcode is none of 0, 8, 13 or 15, or the opcode is 0 and the function field is not 32, illegal_o is high in that cycle and wb_en_o stays low. The register file keeps its contents.
- R7: When valid_i is low, no outputs strobe and no register changes. When valid_i is high and the instruction is legal, wb_en_o is high in the same cycle. The register is updated at the next rising edge, so the next instruction reads the new value.
- R8: A synchronous active-high rst clears all 32 registers to zero.
- R9: The write address is rd for the register-register add and rt for the immediate forms. The shamt field [10:6] has no effect on the add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| result_o | output | 32 | Computed result for the current instruction |
| wb_en_o | output | 1 | Legal valid instruction; the result is written at the next edge |
| wb_addr_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Valid instruction with an unsupported encoding |

## Verification
A scoreboard compares the result, strobe, address and illegal flag of every issued word against an independent model of the register file. Each immediate operation is driven with an immediate whose top bit is set and one whose top bit is clear. This separates sign extension from zero extension and from upper-half placement. The tests also cover overflow wraparound on both add forms, a read-after-write chain, and a load-upper/or-immediate pair that builds a full constant. Writes to register 0, an unsupported opcode, an unsupported function code, a nonzero shamt and a dropped valid are each followed by a read-back, which shows whether any state changed.

// File: rtl/subset_exec_unit.sv
module subset_exec_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output logic [31:0] result_o,
  output logic        wb_en_o,
  output logic [4:0]  wb_addr_o,
  output logic        illegal_o
);

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] FN_ADD  = 6'd32;

  logic [31:0] rf [32];

  wire [5:0]  op    = instr_i[31:26];
  wire [4:0]  rs    = instr_i[25:21];
  wire [4:0]  rt    = instr_i[20:16];
  wire [4:0]  rd    = instr_i[15:11];
  wire [5:0]  funct = instr_i[5:0];
  wire [15:0] imm   = instr_i[15:0];

  wire [31:0] rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];

  wire is_add  = (op == OP_REG) && (funct == FN_ADD);
  wire is_addi = (op == OP_ADDI);
  wire is_ori  = (op == OP_ORI);
  wire is_lui  = (op == OP_LUI);
  wire legal   = is_add | is_addi | is_ori | is_lui;

  always_comb begin
    result_o = 32'd0;
    if (is_add)       result_o = rs_val + rt_val;
    else if (is_addi) result_o = rs_val + {{16{imm[15]}}, imm};
    else if (is_ori)  result_o = rs_val | {16'd0, imm};
    else if (is_lui)  result_o = {imm, 16'd0};
  end

  assign wb_addr_o = is_add ? rd : rt;
  assign wb_en_o   = valid_i & legal;
  assign illegal_o = valid_i & ~legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (wb_en_o && wb_addr_o != 5'd0) begin
      rf[wb_addr_o] <= result_o;
    end
  end

  a_r6_illegal_no_wb: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wb_en_o);

  a_r3_lui_low_clear: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[31:26] == 6'd15) |-> result_o[15:0] == 16'd0);

  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wb_en_o && wb_addr_o != 5'd0) |=> rf[$past(wb_addr_o)] == $past(result_o));

  a_r6_state_held: assert property (@(posedge clk) disable iff (rst)
    (!wb_en_o) |=> rf[$past(instr_i[25:21])] == $past(rs_val) || $past(instr_i[25:21]) == 5'd0);

  a_r5_zero_source: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[31:26] == 6'd13 && instr_i[25:21] == 5'd0 && instr_i[15:0] == 16'd0)
      |-> result_o == 32'd0);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (rf[1] == 32'd0 && rf[31] == 32'd0));

endmodule

// File: tb/subset_exec_unit_test.sv
module subset_exec_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = 32'd0;
  logic [31:0] result_o;
  logic        wb_en_o;
  logic [4:0]  wb_addr_o;
  logic        illegal_o;

  always #4 clk = ~clk;

  subset_exec_unit uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .result_o(result_o), .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o),
    .illegal_o(illegal_o)
  );

  typedef struct {
    logic        v;
    logic        ill;
    logic [31:0] res;
    logic [4:0]  addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] model [32];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [31:0] rtype(input logic [4:0] s, input logic [4:0] t,
                                         input logic [4:0] d, input logic [4:0] sh,
                                         input logic [5:0] fn);
    return {6'd0, s, t, d, sh, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] o, input logic [4:0] s,
                                         input logic [4:0] t, input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  task automatic issue(input logic [31:0] w, input logic v, input string tag);
    exp_t e;
    logic [31:0] a, b;
    logic [15:0] im;
    @(posedge clk); #1;
    instr_i = w;
    valid_i = v;
    a  = model[w[25:21]];
    b  = model[w[20:16]];
    im = w[15:0];
    e.v = v; e.ill = 1'b0; e.res = 32'd0; e.addr = w[20:16]; e.tag = tag;
    case (w[31:26])
      6'd0: if (w[5:0] == 6'd32) begin e.res = a + b; e.addr = w[15:11]; end
            else e.ill = 1'b1;
      6'd8:  e.res = a + {{16{im[15]}}, im};
      6'd13: e.res = a | {16'd0, im};
      6'd15: e.res = {im, 16'd0};
      default: e.ill = 1'b1;
    endcase
    e.ill = e.ill & v;
    if (v && !e.ill && e.addr != 5'd0) model[e.addr] = e.res;
    q.push_back(e);
  endtask

  task automatic peek(input logic [4:0] r, input string tag);
    issue(rtype(r, 5'd0, 5'd0, 5'd0, 6'd32), 1'b1, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    valid_i = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (e.ill) begin
        if (!(illegal_o === 1'b1 && wb_en_o === 1'b0)) begin
          fails++;
          $display("FAIL %s: illegal=%b wb_en=%b expected illegal=1 wb_en=0", e.tag, illegal_o, wb_en_o);
        end
      end else if (e.v) begin
        if (illegal_o !== 1'b0 || wb_en_o !== 1'b1 || result_o !== e.res || wb_addr_o !== e.addr) begin
          fails++;
          $display("FAIL %s: res=%h addr=%0d wb_en=%b ill=%b expected res=%h addr=%0d wb_en=1 ill=0",
                   e.tag, result_o, wb_addr_o, wb_en_o, illegal_o, e.res, e.addr);
        end
      end else begin
        if (wb_en_o !== 1'b0 || illegal_o !== 1'b0) begin
          fails++;
          $display("FAIL %s: wb_en=%b ill=%b expected both 0", e.tag, wb_en_o, illegal_o);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;

    peek(5'd1, "R8 reset r1");
    peek(5'd31, "R8 reset r31");

    issue(itype(6'd15, 5'd0, 5'd8, 16'h00FF), 1'b1, "R3 lui low half");
    issue(itype(6'd13, 5'd8, 5'd8, 16'h0005), 1'b1, "R4 ori builds constant");
    issue(itype(6'd15, 5'd3, 5'd16, 16'h8001), 1'b1, "R3 lui top bit set");
    issue(itype(6'd13, 5'd0, 5'd9, 16'h8000), 1'b1, "R4 ori zero-extend");
    issue(itype(6'd8, 5'd0, 5'd10, 16'hFFFF), 1'b1, "R2 addi sign-extend");
    issue(itype(6'd8, 5'd10, 5'd11, 16'h0001), 1'b1, "R2 addi wrap");
    issue(itype(6'd8, 5'd8, 5'd17, 16'h7FFF), 1'b1, "R2 addi positive");
    issue(rtype(5'd8, 5'd9, 5'd12, 5'd0, 6'd32), 1'b1, "R1 add");
    issue(rtype(5'd10, 5'd10, 5'd13, 5'd0, 6'd32), 1'b1, "R1 add wrap");
    issue(rtype(5'd8, 5'd8, 5'd18, 5'd7, 6'd32), 1'b1, "R9 shamt ignored");
    issue(itype(6'd8, 5'd0, 5'd19, 16'h0000 | {5'd20, 11'd0}), 1'b1, "R9 itype dest rt");
    peek(5'd20, "R9 rd untouched by itype");

    issue(itype(6'd8, 5'd0, 5'd0, 16'h0007), 1'b1, "R5 write r0");
    peek(5'd0, "R5 r0 reads zero");
    issue(rtype(5'd8, 5'd0, 5'd0, 5'd0, 6'd32), 1'b1, "R5 add into r0");
    peek(5'd0, "R5 r0 still zero");

    issue(itype(6'd35, 5'd8, 5'd14, 16'h0004), 1'b1, "R6 bad opcode");
    peek(5'd14, "R6 bad opcode no write");
    issue(rtype(5'd8, 5'd9, 5'd15, 5'd0, 6'd34), 1'b1, "R6 bad funct");
    peek(5'd15, "R6 bad funct no write");

    issue(itype(6'd8, 5'd0, 5'd21, 16'h0055), 1'b0, "R7 valid low");
    peek(5'd21, "R7 valid low no write");
    issue(itype(6'd8, 5'd0, 5'd22, 16'h0003), 1'b1, "R7 first write");
    issue(rtype(5'd22, 5'd22, 5'd22, 5'd0, 6'd32), 1'b1, "R7 read after write");
    peek(5'd22, "R7 chained value");

    do_reset();
    peek(5'd8, "R8 reset clears r8");
    peek(5'd22, "R8 reset clears r22");

    @(posedge clk); #1 valid_i = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule